// File: doc/BRIEF.md
# GPIO Pad Control Register Bank

This block holds the per-pin control state for a row of 8-bit general-purpose ports and turns that state into pad controls: a drive value, a drive enable, and a cleaned-up input value. Each pin has seven control bits. **Source select** chooses the GPIO registers or an internal processor source. **Priority** gives the pin to GPIO control or to the multiplexed peripheral path. The other five are output enable, output data, output inversion, input inversion and open-drain enable. A simple word-wide register port writes and reads these bits.

Every write carries its own bit-enable mask in its upper half-word. Software can therefore change a single pin without first reading the word back. Each control word covers two ports. Read-only words return the synchronised and inverted pad inputs, four ports per word. Open-drain mode drives the pad only low: it asserts the enable for a 0 and releases the pad for a 1, whatever the output-enable bit holds.

Top module: `gpio_pad_ctrl`

## Requirements
- R1: A write changes stored data bit i (0..15) of the addressed word only when bit i+16 of `bus_wdata` is 1. All other stored bits keep their value, and a write with an all-zero upper half-word changes nothing.
- R2: Word address is {function[2:0], word[2:0]}. The function codes are: source select 0, output enable 1, output data 2, input inversion 3, output inversion 4, open drain 5, priority 6, input 7. Control word w holds port 2w in bits 7:0 and port 2w+1 in bits 15:8. Bits 31:16 read as zero.
- R3: Input word k (function 7) holds port 4k+j in byte j. The last word carries only port 8, in bits 7:0. Bytes with no port behind them, including byte 1 of control word 4, read as zero.
- R4: A pin with priority=1, source=1 and open-drain=0 drives `pad_do` = out XOR out-inversion, with `pad_oe` = its output-enable bit. These pad outputs follow a register write in the cycle after the write edge.
- R5: A GPIO-controlled pin with open-drain=1 drives `pad_do`=0 and `pad_oe` = NOT(out XOR out-inversion). Its output-enable bit has no effect.
- R6: A pin with priority=0 takes `pad_do`/`pad_oe` from `periph_do`/`periph_oe`, and its source-select bit is ignored.
- R7: A pin with priority=1 and source=0 takes `pad_do`/`pad_oe` from `proc_do`/`proc_oe`.
- R8: `gpio_in` and the input words equal `pad_in` sampled through two flip-flops, XOR the input-inversion bit. A pad change is visible after the second rising edge, not after the first.
- R9: Writes to input words (function 7) and to control words with index 5..7 change no stored state. Unmapped control words read as zero.
- R10: After reset, priority is 1 for every pin of port 0 and 0 for ports 1..8, and every other control bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 6 | Word address {function, word} |
| bus_wdata | input | 32 | Write word: mask in 31:16, data in 15:0 |
| bus_rdata | output | 32 | Read word for `bus_addr`, combinational |
| pad_in | input | 72 | Raw pad input levels |
| proc_do | input | 72 | Drive value from the internal processor source |
| proc_oe | input | 72 | Drive enable from the internal processor source |
| periph_do | input | 72 | Drive value from the peripheral path |
| periph_oe | input | 72 | Drive enable from the peripheral path |
| pad_do | output | 72 | Drive value per pin |
| pad_oe | output | 72 | Drive enable per pin |
| gpio_in | output | 72 | Synchronised input after inversion |

## Verification
Register writes land on the edge that samples `bus_we`. Read data and pad outputs are combinational from the stored bits. The bench therefore drives a write for one cycle on the falling edge and checks readback and pad outputs on the next falling edge. Pad input changes pass through two flops. The bench checks `gpio_in` one falling edge after a change, expecting the old value, and again after the second edge, expecting the new one, so that R8's latency is pinned down exactly.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  typedef enum logic [2:0] {
    FN_SRC   = 3'd0,
    FN_OE    = 3'd1,
    FN_OUT   = 3'd2,
    FN_IINV  = 3'd3,
    FN_OINV  = 3'd4,
    FN_OD    = 3'd5,
    FN_PRIO  = 3'd6,
    FN_INPUT = 3'd7
  } gpio_fn_e;

  localparam int NUM_CTL_FN = 7;
  localparam int ADDR_W     = 6;
endpackage

// File: rtl/gpio_ctl_bank.sv
module gpio_ctl_bank
  import gpio_pad_pkg::*;
#(
  parameter int NPORT = 9,
  parameter int PW    = 8,
  localparam int NPIN = NPORT * PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [NPIN-1:0]   in_val,
  output logic [31:0]       rdata,
  output logic [NUM_CTL_FN-1:0][NPIN-1:0] ctl
);
  localparam int PINS_PER_CW = 2 * PW;
  localparam int PINS_PER_IW = 4 * PW;
  localparam int NCW = (NPIN + PINS_PER_CW - 1) / PINS_PER_CW;
  localparam int NIW = (NPIN + PINS_PER_IW - 1) / PINS_PER_IW;
  localparam logic [NPIN-1:0] PRIO_RST = {{(NPIN-PW){1'b0}}, {PW{1'b1}}};

  logic [NUM_CTL_FN-1:0][NPIN-1:0] ctl_q, ctl_d;
  logic [2:0] fn_sel, word_sel;
  logic       ctl_we;

  assign fn_sel   = addr[5:3];
  assign word_sel = addr[2:0];
  assign ctl_we   = we && (fn_sel != FN_INPUT) && (int'(word_sel) < NCW);

  // next state: masked bit update
  always_comb begin
    ctl_d = ctl_q;
    for (int f = 0; f < NUM_CTL_FN; f++) begin
      for (int p = 0; p < NPIN; p++) begin
        if (ctl_we && int'(fn_sel) == f && int'(word_sel) == p / PINS_PER_CW
            && wdata[16 + (p % PINS_PER_CW)]) begin
          ctl_d[f][p] = wdata[p % PINS_PER_CW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q        <= '0;
      ctl_q[FN_PRIO] <= PRIO_RST;
    end else if (ctl_we) begin
      ctl_q <= ctl_d;
    end
  end

  assign ctl = ctl_q;

  // read path
  always_comb begin
    logic [NCW*PINS_PER_CW-1:0] cpad;
    logic [NIW*PINS_PER_IW-1:0] ipad;
    cpad = '0;
    ipad = '0;
    rdata = '0;
    if (fn_sel == FN_INPUT) begin
      ipad[NPIN-1:0] = in_val;
      if (int'(word_sel) < NIW) rdata = ipad[int'(word_sel)*PINS_PER_IW +: PINS_PER_IW];
    end else begin
      cpad[NPIN-1:0] = ctl_q[fn_sel];
      if (int'(word_sel) < NCW) rdata[15:0] = cpad[int'(word_sel)*PINS_PER_CW +: PINS_PER_CW];
    end
  end

  p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(ctl_q));
  p_empty_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && wdata[31:16] == 16'h0) |=> $stable(ctl_q));
  p_ro_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr[5:3] == 3'd7) |=> $stable(ctl_q));
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int NPIN = 72
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] raw,
  output logic [NPIN-1:0] synced
);
  logic [NPIN-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
    end
  end

  assign synced = sync_q;

  p_two_stage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sync_q == $past(meta_q)));
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int NPIN = 72
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] src,
  input  logic [NPIN-1:0] oe,
  input  logic [NPIN-1:0] out,
  input  logic [NPIN-1:0] oinv,
  input  logic [NPIN-1:0] od,
  input  logic [NPIN-1:0] prio,
  input  logic [NPIN-1:0] proc_do,
  input  logic [NPIN-1:0] proc_oe,
  input  logic [NPIN-1:0] periph_do,
  input  logic [NPIN-1:0] periph_oe,
  output logic [NPIN-1:0] pad_do,
  output logic [NPIN-1:0] pad_oe
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    logic val, g_do, g_oe;
    always_comb begin
      val = out[p] ^ oinv[p];
      if (od[p]) begin
        g_do = 1'b0;
        g_oe = ~val;
      end else begin
        g_do = val;
        g_oe = oe[p];
      end
      if (!prio[p]) begin
        pad_do[p] = periph_do[p];
        pad_oe[p] = periph_oe[p];
      end else if (!src[p]) begin
        pad_do[p] = proc_do[p];
        pad_oe[p] = proc_oe[p];
      end else begin
        pad_do[p] = g_do;
        pad_oe[p] = g_oe;
      end
    end
  end

  p_od_never_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & pad_do & od & prio & src) == '0));
  p_periph_owns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~prio & ((pad_do ^ periph_do) | (pad_oe ^ periph_oe))) == '0));
  p_proc_owns_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((prio & ~src & ((pad_do ^ proc_do) | (pad_oe ^ proc_oe))) == '0));
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
  import gpio_pad_pkg::*;
#(
  parameter int NPORT = 9,
  parameter int PW    = 8,
  localparam int NPIN = NPORT * PW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  input  logic [NPIN-1:0]   proc_do,
  input  logic [NPIN-1:0]   proc_oe,
  input  logic [NPIN-1:0]   periph_do,
  input  logic [NPIN-1:0]   periph_oe,
  output logic [NPIN-1:0]   pad_do,
  output logic [NPIN-1:0]   pad_oe,
  output logic [NPIN-1:0]   gpio_in
);
  logic [NUM_CTL_FN-1:0][NPIN-1:0] ctl;
  logic [NPIN-1:0] synced;

  gpio_in_sync #(.NPIN(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw(pad_in), .synced(synced)
  );

  assign gpio_in = synced ^ ctl[FN_IINV];

  gpio_ctl_bank #(.NPORT(NPORT), .PW(PW)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .in_val(gpio_in), .rdata(bus_rdata), .ctl(ctl)
  );

  gpio_pin_mux #(.NPIN(NPIN)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .src(ctl[FN_SRC]), .oe(ctl[FN_OE]), .out(ctl[FN_OUT]),
    .oinv(ctl[FN_OINV]), .od(ctl[FN_OD]), .prio(ctl[FN_PRIO]),
    .proc_do(proc_do), .proc_oe(proc_oe),
    .periph_do(periph_do), .periph_oe(periph_oe),
    .pad_do(pad_do), .pad_oe(pad_oe)
  );
endmodule

// File: tb/tb_gpio_pad_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_pad_ctrl;
  localparam int NPIN = 72;
  logic clk = 1'b0;
  logic rst_n;
  logic bus_we;
  logic [5:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [NPIN-1:0] pad_in, proc_do, proc_oe, periph_do, periph_oe;
  logic [NPIN-1:0] pad_do, pad_oe, gpio_in;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_pad_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .proc_do(proc_do), .proc_oe(proc_oe), .periph_do(periph_do),
    .periph_oe(periph_oe), .pad_do(pad_do), .pad_oe(pad_oe), .gpio_in(gpio_in)
  );

  // {addr, write word, expected low half on readback}
  localparam int NV = 10;
  localparam logic [53:0] VEC [NV] = '{
    {6'h10, 32'h0001_0001, 16'h0001},  // R1 set pin 0
    {6'h10, 32'h0100_0100, 16'h0101},  // R1 set pin 8
    {6'h10, 32'h0001_0000, 16'h0100},  // R1 clear pin 0 only
    {6'h10, 32'h0000_FFFF, 16'h0100},  // R1 empty mask
    {6'h10, 32'hFFFF_A5A5, 16'hA5A5},  // R1 full mask
    {6'h09, 32'h00FF_1234, 16'h0034},  // R2 byte0 only
    {6'h28, 32'h0001_0000, 16'h0000},  // R1 open-drain clear
    {6'h30, 32'hFF00_FFFF, 16'hFFFF},  // R10 port0 prio kept, port1 set
    {6'h34, 32'hFFFF_FFFF, 16'h00FF},  // R3 byte1 of word 4 unused
    {6'h02, 32'h0F0F_FFFF, 16'h0F0F}   // R2 src word 2
  };

  task automatic check(input string req, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0;
    proc_do = '0; proc_oe = '0;
    proc_do[7:0] = 8'h3C; proc_oe[7:0] = 8'hC3;
    periph_do = {9{8'hAA}}; periph_oe = {9{8'h55}};
    do_reset();

    // R10 reset state
    rd(6'h30, r); check("R10 prio w0", r, 32'h0000_00FF);
    rd(6'h31, r); check("R10 prio w1", r, 32'h0);
    rd(6'h10, r); check("R10 out w0", r, 32'h0);
    check("R7 proc drive port0", pad_do[7:0], 8'h3C);
    check("R7 proc oe port0", pad_oe[7:0], 8'hC3);
    check("R6 periph drive ports1-8", pad_do[71:8], periph_do[71:8]);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][53:48], VEC[i][47:16]);
      rd(VEC[i][53:48], r);
      check($sformatf("R1/R2 vec %0d", i), r, {16'h0, VEC[i][15:0]});
    end

    // directed
    do_reset();
    // R4 push-pull with inversion
    wr(6'h00, 32'h00FF_00FF);
    wr(6'h10, 32'h00FF_0055);
    wr(6'h08, 32'h00FF_000F);
    wr(6'h20, 32'h00FF_0003);
    check("R4 pad_do", pad_do[7:0], 8'h56);
    check("R4 pad_oe", pad_oe[7:0], 8'h0F);
    // R5 open drain on pins 4..7
    wr(6'h28, 32'h00FF_00F0);
    check("R5 pad_do", pad_do[7:0], 8'h06);
    check("R5 pad_oe", pad_oe[7:0], 8'hAF);
    wr(6'h08, 32'h00FF_0000);
    check("R5 oe ignored under od", pad_oe[7:0], 8'hA0);
    // R6 source bit of port1 ignored while prio=0
    wr(6'h00, 32'hFF00_FF00);
    check("R6 port1 do", pad_do[15:8], 8'hAA);
    check("R6 port1 oe", pad_oe[15:8], 8'h55);
    // R6 port0 handed to peripheral
    wr(6'h30, 32'h00FF_0000);
    check("R6 port0 do", pad_do[7:0], 8'hAA);
    // R7 back to prio, source cleared
    wr(6'h30, 32'h00FF_00FF);
    wr(6'h00, 32'h00FF_0000);
    check("R7 port0 do", pad_do[7:0], 8'h3C);
    check("R7 port0 oe", pad_oe[7:0], 8'hC3);

    // R8 synchroniser latency and inversion
    wr(6'h18, 32'h00FF_000F);
    @(negedge clk);
    pad_in[7:0] = 8'h33;
    pad_in[39:32] = 8'h11; pad_in[47:40] = 8'h22;
    pad_in[55:48] = 8'h33; pad_in[63:56] = 8'h44;
    pad_in[71:64] = 8'h81;
    @(negedge clk);
    check("R8 one edge old value", gpio_in[7:0], 8'h0F);
    @(negedge clk);
    check("R8 two edges new value", gpio_in[7:0], 8'h3C);
    rd(6'h38, r); check("R8 input word0", r, 32'h0000_003C);
    rd(6'h39, r); check("R3 input word1", r, 32'h4433_2211);
    rd(6'h3A, r); check("R3 input word2", r, 32'h0000_0081);

    // R9 read-only and unmapped writes
    wr(6'h38, 32'hFFFF_FFFF);
    rd(6'h18, r); check("R9 iinv unchanged", r, 32'h0000_000F);
    rd(6'h38, r); check("R9 input unchanged", r, 32'h0000_003C);
    wr(6'h07, 32'hFFFF_FFFF);
    rd(6'h07, r); check("R9 unmapped reads zero", r, 32'h0);
    rd(6'h00, r); check("R9 src w0 unchanged", r, 32'h0000_FF00);

    // R2 byte placement at pads: word 3 = ports 6,7
    wr(6'h33, 32'hFFFF_FFFF);
    wr(6'h03, 32'hFFFF_FFFF);
    wr(6'h13, 32'hFFFF_1234);
    check("R2 port6 do", pad_do[55:48], 8'h34);
    check("R2 port7 do", pad_do[63:56], 8'h12);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule